// File: doc/BRIEF.md
# Operand-2 Barrel Shifter

This block forms the second operand of a 32-bit data-processing ALU. It has two operand forms. In the immediate form, a small constant is rotated into position. In the register form, a source register value is shifted by one of four shift kinds. The shift amount comes either from a 5-bit field in the instruction word or from the low byte of a second register value. The block also produces the shifter carry, which the ALU uses when it updates its flags. Register-file reads happen outside the block, so both register values arrive on input ports. The decoder supplies only the fields the shifter needs.

The shift logic is purely combinational. The operand, the carry and an illegal-encoding flag are captured in an output register when the input strobe `inValid` is high. The result therefore appears one clock after the strobe, and a bench can compare it cycle by cycle. The illegal flag is raised when the amount is taken from a register and that register index names the program counter (index 15).

Top module: `opShifter`

## Requirements
- R1: Results appear on `operand`, `carryOut` and `illegal` one clock after a cycle with `inValid` high, and `outValid` follows `inValid` with the same one-clock delay. When `inValid` is low, the three results keep their previous values. During reset all outputs are zero.
- R2: With `useImm` = 1, `operand` equals `immByte` zero-extended to 32 bits and rotated right by 2 × `immRot`. `carryOut` equals `carryIn` when `immRot` is 0, and `operand[31]` otherwise.
- R3: `shiftKind` encodes 00 = logical left, 01 = logical right, 10 = arithmetic right, 11 = rotate right. With `amtFromReg` = 0, the amount is `amtField` (0 to 31).
- R4: In the register form, an effective amount of zero (from either source) gives `operand` = `srcVal` and `carryOut` = `carryIn`, for every shift kind.
- R5: With `amtFromReg` = 1, the amount is `amtRegVal[7:0]`. Bits 31:8 of `amtRegVal` have no effect on any output.
- R6: For a logical shift by n (1 to 31), vacated bits fill with zeros. The carry is the last bit shifted out: `srcVal[32-n]` for a left shift and `srcVal[n-1]` for a right shift.
- R7: A logical shift by exactly 32 gives zero, with carry `srcVal[0]` (left) or `srcVal[31]` (right). A logical shift by more than 32 gives zero with carry 0.
- R8: An arithmetic right shift by n (1 to 31) fills with the sign bit, with carry `srcVal[n-1]`. For n ≥ 32, `operand` is 32 copies of `srcVal[31]` and the carry equals `srcVal[31]`.
- R9: A rotate right by a nonzero amount n rotates by n mod 32, and `carryOut` equals the resulting `operand[31]`. A nonzero multiple of 32 leaves `srcVal` unchanged, with carry `srcVal[31]`.
- R10: With `useImm` = 0, `amtFromReg` = 1 and `amtRegIdx` = 15, `illegal` is 1, `operand` is 0 and `carryOut` equals `carryIn`. Every other index, and every case where `amtFromReg` = 0 or `useImm` = 1, gives `illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input strobe; captures a result |
| useImm | input | 1 | 1 selects the rotated-immediate form |
| immByte | input | 8 | Immediate constant |
| immRot | input | 4 | Immediate rotate field (rotation is twice this value) |
| shiftKind | input | 2 | Shift kind for the register form |
| amtFromReg | input | 1 | 1 takes the amount from `amtRegVal` |
| amtField | input | 5 | Amount from the instruction field |
| amtRegIdx | input | 4 | Index of the amount register |
| srcVal | input | 32 | Register value being shifted |
| amtRegVal | input | 32 | Value of the amount register |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | Result valid, one clock after `inValid` |
| operand | output | 32 | Shifted or rotated operand |
| carryOut | output | 1 | Shifter carry |
| illegal | output | 1 | Amount register names the program counter |

## Verification
The bench sweeps every register amount from 0 to 41, plus 255, across all four shift kinds and several bit patterns. This covers the edges at 0, 31, 32 and 33. An off-by-one clamp would return the wrong carry at amount 32, or a nonzero carry above 32. A rotate that does not wrap at 32 would clear the operand instead of passing it through. A byte decode that reads too many bits would turn a small amount into a huge one.

Every immediate rotation is checked, because a design that drops the doubling, or that always forces the carry, fails there. The bench also walks all sixteen amount-register indices, to catch an illegal decode that ignores the operand form or the amount source. A final test confirms that the outputs hold while the strobe is low.

// File: rtl/opShiftPkg.sv
package opShiftPkg;

  localparam int unsigned OP_W   = 32;
  localparam int unsigned AMT_W  = $clog2(OP_W + 2);
  localparam int unsigned ROTA_W = $clog2(OP_W);

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shiftKind_e;

  // strobes from control to the shift datapath
  typedef struct packed {
    logic               immForm;
    logic               illegal;
    logic               passThru;
    shiftKind_e         kind;
    logic [AMT_W-1:0]   amt;     // clamped to OP_W+1
    logic [ROTA_W-1:0]  rotAmt;  // rotate distance, modulo OP_W
  } shiftStrobe_t;

endpackage

// File: rtl/opShiftCtrl.sv
module opShiftCtrl
  import opShiftPkg::*;
#(
  parameter int DATA_W    = OP_W,
  parameter int REG_AMT_W = 8,
  parameter int FLD_W     = 5,
  parameter int ROT_W     = 4,
  parameter int IDX_W     = 4,
  parameter int PC_IDX    = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              useImm,
  input  logic [ROT_W-1:0]  immRot,
  input  logic [1:0]        shiftKind,
  input  logic              amtFromReg,
  input  logic [FLD_W-1:0]  amtField,
  input  logic [IDX_W-1:0]  amtRegIdx,
  input  logic [DATA_W-1:0] amtRegVal,
  output shiftStrobe_t      strobe
);

  localparam int CLAMP = DATA_W + 1;

  logic [REG_AMT_W-1:0] rawAmt;
  logic                 unusedAmtHi;

  assign unusedAmtHi = ^amtRegVal[DATA_W-1:REG_AMT_W];

  always_comb begin
    rawAmt          = amtFromReg ? amtRegVal[REG_AMT_W-1:0] : REG_AMT_W'(amtField);
    strobe.immForm  = useImm;
    strobe.illegal  = !useImm && amtFromReg && (amtRegIdx == IDX_W'(PC_IDX));
    strobe.passThru = !useImm && (rawAmt == '0);
    strobe.kind     = shiftKind_e'(shiftKind);
    strobe.amt      = (32'(rawAmt) > CLAMP) ? AMT_W'(CLAMP) : AMT_W'(rawAmt);
    strobe.rotAmt   = useImm ? ROTA_W'({immRot, 1'b0}) : rawAmt[ROTA_W-1:0];
  end

  // R10
  ill_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.illegal |-> (!useImm && amtFromReg));

  // R5
  amt_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(strobe.amt) <= CLAMP);

endmodule

// File: rtl/opShiftCore.sv
module opShiftCore
  import opShiftPkg::*;
#(
  parameter int DATA_W = OP_W,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobe_t      strobe,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [IMM_W-1:0]  immByte,
  input  logic              carryIn,
  output logic [DATA_W-1:0] res,
  output logic              carry
);

  localparam int NKIND = 4;

  logic [DATA_W-1:0] kindRes   [NKIND];
  logic              kindCarry [NKIND];

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    if (k == int'(SH_LSL)) begin : g_lsl
      logic [2*DATA_W:0] wide;
      always_comb begin
        wide         = {{(DATA_W+1){1'b0}}, srcVal} << strobe.amt;
        kindRes[k]   = wide[DATA_W-1:0];
        kindCarry[k] = wide[DATA_W];
      end
    end else if (k == int'(SH_LSR)) begin : g_lsr
      logic [DATA_W:0] t;
      always_comb begin
        t            = {srcVal, 1'b0} >> strobe.amt;
        kindRes[k]   = t[DATA_W:1];
        kindCarry[k] = t[0];
      end
    end else if (k == int'(SH_ASR)) begin : g_asr
      logic [AMT_W-1:0]   amtA;
      logic signed [DATA_W:0] t;
      always_comb begin
        amtA         = (strobe.amt > AMT_W'(DATA_W)) ? AMT_W'(DATA_W) : strobe.amt;
        t            = $signed({srcVal, 1'b0}) >>> amtA;
        kindRes[k]   = t[DATA_W:1];
        kindCarry[k] = t[0];
      end
    end else begin : g_ror
      logic [2*DATA_W-1:0] t;
      always_comb begin
        t            = {srcVal, srcVal} >> strobe.rotAmt;
        kindRes[k]   = t[DATA_W-1:0];
        kindCarry[k] = t[DATA_W-1];
      end
    end
  end

  logic [2*DATA_W-1:0] immWide;
  logic [DATA_W-1:0]   immExt;

  always_comb begin
    immExt  = DATA_W'(immByte);
    immWide = {immExt, immExt} >> strobe.rotAmt;
    if (strobe.immForm) begin
      res   = immWide[DATA_W-1:0];
      carry = (strobe.rotAmt == '0) ? carryIn : immWide[DATA_W-1];
    end else if (strobe.illegal) begin
      res   = '0;
      carry = carryIn;
    end else if (strobe.passThru) begin
      res   = srcVal;
      carry = carryIn;
    end else begin
      res   = kindRes[strobe.kind];
      carry = kindCarry[strobe.kind];
    end
  end

  // R4
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.passThru && !strobe.illegal) |-> (res == srcVal && carry == carryIn));

  // R2
  imm_norot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.immForm && strobe.rotAmt == '0) |-> (res == DATA_W'(immByte) && carry == carryIn));

  // R9
  ror_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.immForm && !strobe.illegal && !strobe.passThru && strobe.kind == SH_ROR)
      |-> (carry == res[DATA_W-1]));

endmodule

// File: rtl/opShiftOut.sv
module opShiftOut
  import opShiftPkg::*;
#(
  parameter int DATA_W = OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] res,
  input  logic              carry,
  input  logic              ill,
  output logic              outValid,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut,
  output logic              illegal
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      operand  <= '0;
      carryOut <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        operand  <= res;
        carryOut <= carry;
        illegal  <= ill;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(operand) && $stable(carryOut) && $stable(illegal) && !outValid));

  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (operand == '0));

endmodule

// File: rtl/opShifter.sv
module opShifter
  import opShiftPkg::*;
#(
  parameter int DATA_W = OP_W,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int FLD_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immByte,
  input  logic [ROT_W-1:0]  immRot,
  input  logic [1:0]        shiftKind,
  input  logic              amtFromReg,
  input  logic [FLD_W-1:0]  amtField,
  input  logic [IDX_W-1:0]  amtRegIdx,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] amtRegVal,
  input  logic              carryIn,
  output logic              outValid,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut,
  output logic              illegal
);

  shiftStrobe_t      strobe;
  logic [DATA_W-1:0] res;
  logic              carry;

  opShiftCtrl #(
    .DATA_W(DATA_W), .REG_AMT_W(8), .FLD_W(FLD_W), .ROT_W(ROT_W),
    .IDX_W(IDX_W), .PC_IDX(15)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .useImm(useImm), .immRot(immRot),
    .shiftKind(shiftKind), .amtFromReg(amtFromReg), .amtField(amtField),
    .amtRegIdx(amtRegIdx), .amtRegVal(amtRegVal), .strobe(strobe)
  );

  opShiftCore #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcVal(srcVal),
    .immByte(immByte), .carryIn(carryIn), .res(res), .carry(carry)
  );

  opShiftOut #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rstN(rstN), .inValid(inValid), .res(res), .carry(carry),
    .ill(strobe.illegal), .outValid(outValid), .operand(operand),
    .carryOut(carryOut), .illegal(illegal)
  );

endmodule

// File: tb/opShifter_test.sv
`timescale 1ns/1ps
module opShifter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        useImm = 1'b0;
  logic [7:0]  immByte = '0;
  logic [3:0]  immRot = '0;
  logic [1:0]  shiftKind = '0;
  logic        amtFromReg = 1'b0;
  logic [4:0]  amtField = '0;
  logic [3:0]  amtRegIdx = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] amtRegVal = '0;
  logic        carryIn = 1'b0;
  logic        outValid;
  logic [31:0] operand;
  logic        carryOut;
  logic        illegal;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  opShifter uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .useImm(useImm),
    .immByte(immByte), .immRot(immRot), .shiftKind(shiftKind),
    .amtFromReg(amtFromReg), .amtField(amtField), .amtRegIdx(amtRegIdx),
    .srcVal(srcVal), .amtRegVal(amtRegVal), .carryIn(carryIn),
    .outValid(outValid), .operand(operand), .carryOut(carryOut),
    .illegal(illegal)
  );

  task automatic checkOut(input string tag, input logic [31:0] expOp,
                          input logic expC, input logic expIll, input logic expV);
    total++;
    if (operand !== expOp || carryOut !== expC || illegal !== expIll || outValid !== expV) begin
      bad++;
      $display("FAIL %s: got op=%h c=%b ill=%b v=%b, expected op=%h c=%b ill=%b v=%b",
               tag, operand, carryOut, illegal, outValid, expOp, expC, expIll, expV);
    end
  endtask

  // apply at negedge, register at posedge, sample at following negedge
  task automatic drive(input logic uImm, input logic [7:0] imm, input logic [3:0] rot,
                       input logic [1:0] kind, input logic fromReg, input logic [4:0] fld,
                       input logic [3:0] idx, input logic [31:0] src, input logic [31:0] rv,
                       input logic cin);
    useImm = uImm; immByte = imm; immRot = rot; shiftKind = kind;
    amtFromReg = fromReg; amtField = fld; amtRegIdx = idx; srcVal = src;
    amtRegVal = rv; carryIn = cin; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  // bit-serial reference: returns {carry, value}
  function automatic logic [32:0] refShift(input int kind, input int n,
                                           input logic [31:0] s, input logic cin);
    logic [31:0] v;
    logic c;
    v = s;
    c = cin;
    if (n == 0) return {cin, s};
    case (kind)
      0: for (int i = 0; i < n; i++) begin c = v[31]; v = {v[30:0], 1'b0}; end
      1: for (int i = 0; i < n; i++) begin c = v[0];  v = {1'b0, v[31:1]}; end
      2: for (int i = 0; i < n; i++) begin c = v[0];  v = {v[31], v[31:1]}; end
      default: begin
        for (int i = 0; i < n % 32; i++) v = {v[0], v[31:1]};
        c = v[31];
      end
    endcase
    return {c, v};
  endfunction

  function automatic logic [32:0] refImm(input logic [7:0] imm, input int rot, input logic cin);
    logic [31:0] v;
    v = {24'b0, imm};
    for (int i = 0; i < 2 * rot; i++) v = {v[0], v[31:1]};
    return {(rot == 0) ? cin : v[31], v};
  endfunction

  function automatic string regTag(input int kind, input int n);
    if (n == 0) return "R4 zero amount";
    if (kind == 3) return "R9 rotate";
    if (kind == 2) return "R8 arith right";
    if (n < 32) return "R6 logical";
    return "R7 logical wide";
  endfunction

  logic [31:0] pats [3] = '{32'hC3A5_9612, 32'h5A3C_E781, 32'h8000_0001};
  logic [7:0]  imms [4] = '{8'h81, 8'hFF, 8'h01, 8'h5C};

  initial begin
    logic [32:0] e;
    logic [31:0] holdOp;
    logic        holdC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut("R1 reset state", 32'h0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 32'h0, 1'b0, 1'b0, 1'b0);

    // register-specified amounts: R5 upper bits filled with noise
    for (int kind = 0; kind < 4; kind++)
      for (int p = 0; p < 3; p++)
        for (int idx = 0; idx < 43; idx++) begin
          int n;
          n = (idx == 42) ? 255 : idx;
          drive(1'b0, 8'h00, 4'h0, 2'(kind), 1'b1, 5'd0, 4'd3, pats[p],
                {24'hA5C3_7E, 8'(n)}, 1'(n % 2));
          e = refShift(kind, n, pats[p], 1'(n % 2));
          checkOut(regTag(kind, n), e[31:0], e[32], 1'b0, 1'b1);
        end

    // R5: same byte, different upper bits, same result
    drive(1'b0, 8'h00, 4'h0, 2'd0, 1'b1, 5'd0, 4'd2, 32'h1234_5678, 32'hFFFF_FF03, 1'b0);
    e = refShift(0, 3, 32'h1234_5678, 1'b0);
    checkOut("R5 upper amount bits ignored", e[31:0], e[32], 1'b0, 1'b1);
    drive(1'b0, 8'h00, 4'h0, 2'd3, 1'b1, 5'd0, 4'd2, 32'h1234_5678, 32'h0100_0000, 1'b1);
    checkOut("R5 byte zero with upper bits set", 32'h1234_5678, 1'b1, 1'b0, 1'b1);

    // R3: immediate amount field, every value
    for (int kind = 0; kind < 4; kind++)
      for (int p = 0; p < 2; p++)
        for (int n = 0; n < 32; n++) begin
          drive(1'b0, 8'h00, 4'h0, 2'(kind), 1'b0, 5'(n), 4'd15, pats[p],
                32'hFFFF_FFFF, 1'(p));
          e = refShift(kind, n, pats[p], 1'(p));
          checkOut((n == 0) ? "R4 zero field amount" : "R3 field amount",
                   e[31:0], e[32], 1'b0, 1'b1);
        end

    // R2: rotated immediate; amount register 15 irrelevant here
    for (int i = 0; i < 4; i++)
      for (int r = 0; r < 16; r++) begin
        drive(1'b1, imms[i], 4'(r), 2'(r % 4), 1'(r % 2), 5'd7, 4'd15,
              32'hDEAD_BEEF, 32'h0000_0009, 1'(i % 2));
        e = refImm(imms[i], r, 1'(i % 2));
        checkOut("R2 rotated immediate", e[31:0], e[32], 1'b0, 1'b1);
      end

    // R10: amount register index walk
    for (int idx = 0; idx < 16; idx++) begin
      drive(1'b0, 8'h00, 4'h0, 2'd1, 1'b1, 5'd0, 4'(idx), 32'hF0F0_1234,
            32'h0000_0004, 1'b1);
      if (idx == 15) checkOut("R10 program counter as amount", 32'h0, 1'b1, 1'b1, 1'b1);
      else begin
        e = refShift(1, 4, 32'hF0F0_1234, 1'b1);
        checkOut("R10 legal index", e[31:0], e[32], 1'b0, 1'b1);
      end
    end
    drive(1'b0, 8'h00, 4'h0, 2'd1, 1'b0, 5'd4, 4'd15, 32'hF0F0_1234, 32'h0, 1'b0);
    e = refShift(1, 4, 32'hF0F0_1234, 1'b0);
    checkOut("R10 field amount with index 15", e[31:0], e[32], 1'b0, 1'b1);

    // R1: hold while strobe is low
    drive(1'b0, 8'h00, 4'h0, 2'd0, 1'b0, 5'd5, 4'd0, 32'h0000_00FF, 32'h0, 1'b0);
    e = refShift(0, 5, 32'h0000_00FF, 1'b0);
    holdOp = e[31:0];
    holdC = e[32];
    checkOut("R1 strobed result", holdOp, holdC, 1'b0, 1'b1);
    inValid = 1'b0;
    srcVal = 32'h8765_4321;
    amtRegIdx = 4'd15;
    amtFromReg = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkOut("R1 hold without strobe", holdOp, holdC, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    checkOut("R1 hold second cycle", holdOp, holdC, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule